// File: doc/BRIEF.md
# CAN Error Warning Interrupt Unit

This unit watches the transmit and receive error counters of a CAN controller and turns the warning threshold crossing into sticky interrupt flags. Each counter is compared against a warning limit of 96. The comparison drives a live warning level. Its rising edge latches a flag, and software clears the flag by writing a one to it.

Latching is allowed only while a global warning-enable input is high. While that input is low, a latched flag is hidden, and it shows up again once the input returns high. The transmit flag cannot be set while the controller is bus-off. In freeze mode, neither flag nor the edge-detection history changes. A crossing that happens during freeze is therefore caught once freeze ends, provided the level is still high.

Each flag has its own mask bit. The interrupt request is the registered OR of the masked, visible flags. A 32-bit status word presents three bits:
- the synchronization status at bit 18;
- the transmit flag at bit 17;
- the receive flag at bit 16.

All other bits of the status word read as zero.

Top module: `can_warn_irq`

## Requirements
- R1: `tx_warn` is 1 exactly when `tx_err_cnt` >= 96, and `rx_warn` is 1 exactly when `rx_err_cnt` >= 96. Both are combinational.
- R2: A flag latches on the clock edge at which its warning level is 1 while the level sampled at the previous non-freeze edge was 0. A level that stays high does not set the flag again after it has been cleared.
- R3: A flag cannot latch while `warn_en` is 0. While `warn_en` is 0, the flag outputs and status bits read 0. A flag that was latched before `warn_en` fell reads 1 again once `warn_en` returns to 1.
- R4: A write with `wr_en`=1 clears the transmit flag when `wr_data[17]`=1 and the receive flag when `wr_data[16]`=1. A 0 in either bit leaves that flag unchanged.
- R5: While `bus_off`=1, the transmit flag never latches. The receive flag is unaffected by `bus_off`.
- R6: While `freeze`=1, neither flag changes, whether by set or by clear. The previous-level history also holds, so a crossing during freeze latches at the first non-freeze edge if the level is still 1.
- R7: `irq` is a register. At each edge it takes (visible tx flag AND `tx_mask`) OR (visible rx flag AND `rx_mask`).
- R8: When a set condition and a write-one-to-clear hit the same flag at the same edge, the flag ends up at 1.
- R9: `status_word` has bit 18 = `synced`, bit 17 = visible tx flag, bit 16 = visible rx flag, and all other bits 0. `sync_stat` equals `synced`.
- R10: While `rst_n`=0, the flags, `irq` and the history are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_err_cnt | input | 8 | Transmit error counter |
| rx_err_cnt | input | 8 | Receive error counter |
| warn_en | input | 1 | Warning interrupt enable |
| tx_mask | input | 1 | Transmit flag interrupt mask |
| rx_mask | input | 1 | Receive flag interrupt mask |
| bus_off | input | 1 | Controller is bus-off |
| freeze | input | 1 | Freeze mode active |
| synced | input | 1 | Controller synchronized to bus |
| wr_en | input | 1 | Status word write strobe |
| wr_data | input | 32 | Write data, 1 bits clear flags |
| tx_warn | output | 1 | Transmit warning level |
| rx_warn | output | 1 | Receive warning level |
| tx_warn_flag | output | 1 | Visible transmit warning flag |
| rx_warn_flag | output | 1 | Visible receive warning flag |
| sync_stat | output | 1 | Synchronization status |
| irq | output | 1 | Interrupt request |
| status_word | output | 32 | Error status readout |

## Verification
The hardest case to reach from the ports is a crossing that happens inside a freeze window and is then reported late. To reach it, the counter has to rise while `freeze` is held, and `freeze` has to drop while the level is still high.

A second hard case is a flag that is latched, then hidden by `warn_en`, then revealed again.

Directed sequences build both cases, as well as a clear that collides with a new crossing. Random phases keep the counters near 96 so that edges, bus-off, freeze and writes interleave often. A bench model predicts every output at each edge.

// File: rtl/can_warn_irq.sv
module can_warn_irq #(
  parameter int CNT_W      = 8,
  parameter int WARN_LIMIT = 96,
  parameter int TX_BIT     = 17,
  parameter int RX_BIT     = 16,
  parameter int SYNC_BIT   = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_err_cnt,
  input  logic [CNT_W-1:0] rx_err_cnt,
  input  logic             warn_en,
  input  logic             tx_mask,
  input  logic             rx_mask,
  input  logic             bus_off,
  input  logic             freeze,
  input  logic             synced,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic             tx_warn,
  output logic             rx_warn,
  output logic             tx_warn_flag,
  output logic             rx_warn_flag,
  output logic             sync_stat,
  output logic             irq,
  output logic [31:0]      status_word
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WARN_LIMIT);

  logic tx_prev, rx_prev, tx_flag, rx_flag;
  logic tx_set, rx_set, tx_clr, rx_clr;

  assign tx_warn = tx_err_cnt >= LIMIT;
  assign rx_warn = rx_err_cnt >= LIMIT;

  assign tx_set = warn_en && !bus_off && tx_warn && !tx_prev;
  assign rx_set = warn_en && rx_warn && !rx_prev;
  assign tx_clr = wr_en && wr_data[TX_BIT];
  assign rx_clr = wr_en && wr_data[RX_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_prev <= 1'b0;
      rx_prev <= 1'b0;
      tx_flag <= 1'b0;
      rx_flag <= 1'b0;
    end else if (!freeze) begin
      tx_prev <= tx_warn;
      rx_prev <= rx_warn;
      tx_flag <= tx_set | (tx_flag & ~tx_clr);
      rx_flag <= rx_set | (rx_flag & ~rx_clr);
    end
  end

  assign tx_warn_flag = tx_flag & warn_en;
  assign rx_warn_flag = rx_flag & warn_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (tx_warn_flag & tx_mask) | (rx_warn_flag & rx_mask);
  end

  assign sync_stat = synced;

  always_comb begin
    status_word           = '0;
    status_word[SYNC_BIT] = synced;
    status_word[TX_BIT]   = tx_warn_flag;
    status_word[RX_BIT]   = rx_warn_flag;
  end
endmodule

// File: rtl/can_warn_irq_chk.sv
module can_warn_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        warn_en,
  input logic        tx_mask,
  input logic        rx_mask,
  input logic        bus_off,
  input logic        freeze,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        rx_warn,
  input logic        tx_warn_flag,
  input logic        rx_warn_flag,
  input logic        irq
);
  AST_TX_NO_SET_BUS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && warn_en && !tx_warn_flag) |=> (!warn_en || !tx_warn_flag)); // R5
  AST_FREEZE_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && warn_en) |=> (!warn_en || ($stable(tx_warn_flag) && $stable(rx_warn_flag)))); // R6
  AST_W1C_CLEARS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && wr_en && wr_data[16] && !rx_warn) |=> !rx_warn_flag); // R4
  AST_NO_SET_WITHOUT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_en && !rx_warn_flag && !rx_warn) |=> (!warn_en || !rx_warn_flag)); // R2
  AST_IRQ_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past((tx_warn_flag && tx_mask) || (rx_warn_flag && rx_mask))); // R7
endmodule

bind can_warn_irq can_warn_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .warn_en(warn_en), .tx_mask(tx_mask), .rx_mask(rx_mask),
  .bus_off(bus_off), .freeze(freeze), .wr_en(wr_en), .wr_data(wr_data),
  .rx_warn(rx_warn), .tx_warn_flag(tx_warn_flag), .rx_warn_flag(rx_warn_flag), .irq(irq)
);

// File: tb/sim_can_warn_irq.sv
module sim_can_warn_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] tx_err_cnt = '0, rx_err_cnt = '0;
  logic warn_en = 0, tx_mask = 0, rx_mask = 0, bus_off = 0, freeze = 0, synced = 0, wr_en = 0;
  logic [31:0] wr_data = '0;
  logic tx_warn, rx_warn, tx_warn_flag, rx_warn_flag, sync_stat, irq;
  logic [31:0] status_word;

  int total = 0, bad = 0;
  bit done = 0;
  bit m_txf = 0, m_rxf = 0, m_txp = 0, m_rxp = 0, m_irq = 0;

  always #2.5 clk = ~clk;

  can_warn_irq u0 (.*);

  function automatic bit lvl(input logic [7:0] c);
    return c >= 8'd96;
  endfunction

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    w[18] = synced;
    w[17] = m_txf & warn_en;
    w[16] = m_rxf & warn_en;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic model_edge();
    bit ts, rs, nirq;
    nirq = (m_txf & warn_en & tx_mask) | (m_rxf & warn_en & rx_mask);
    if (!freeze) begin
      ts = warn_en & ~bus_off & lvl(tx_err_cnt) & ~m_txp;
      rs = warn_en & lvl(rx_err_cnt) & ~m_rxp;
      m_txf = ts | (m_txf & ~(wr_en & wr_data[17]));
      m_rxf = rs | (m_rxf & ~(wr_en & wr_data[16]));
      m_txp = lvl(tx_err_cnt);
      m_rxp = lvl(rx_err_cnt);
    end
    m_irq = nirq;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({tag, " tx_warn_flag"}, {31'd0, tx_warn_flag}, {31'd0, m_txf & warn_en});
    chk({tag, " rx_warn_flag"}, {31'd0, rx_warn_flag}, {31'd0, m_rxf & warn_en});
    chk("R7 irq", {31'd0, irq}, {31'd0, m_irq});
    chk("R9 status_word", status_word, exp_word());
    chk("R1 levels", {30'd0, tx_warn, rx_warn}, {30'd0, lvl(tx_err_cnt), lvl(rx_err_cnt)});
    chk("R9 sync_stat", {31'd0, sync_stat}, {31'd0, synced});
  endtask

  task automatic wr(input bit t, input bit r);
    wr_en = 1;
    wr_data = '0;
    wr_data[17] = t;
    wr_data[16] = r;
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    tx_err_cnt = 8'd120; synced = 1; warn_en = 1;
    repeat (3) @(negedge clk);
    chk("R10 reset flags", {30'd0, tx_warn_flag, rx_warn_flag}, 32'd0);
    chk("R10 reset irq", {31'd0, irq}, 32'd0);
    tx_err_cnt = 8'd0;
    rst_n = 1;
    tx_mask = 1; rx_mask = 1;

    tx_err_cnt = 8'd95; step("R1");
    chk("R1 below", {31'd0, tx_warn}, 32'd0);
    tx_err_cnt = 8'd96; step("R2");
    chk("R2 tx set on crossing", {31'd0, tx_warn_flag}, 32'd1);
    wr(1, 0); step("R4");
    chk("R4 tx cleared", {31'd0, tx_warn_flag}, 32'd0);
    wr_en = 0; tx_err_cnt = 8'd130; repeat (3) step("R2");
    chk("R2 no reset while level stays high", {31'd0, tx_warn_flag}, 32'd0);

    rx_err_cnt = 8'd100; step("R2");
    wr(0, 0); wr_data = 32'hFFFC_FFFF; step("R4");
    wr_en = 0;
    chk("R4 write 0 keeps rx flag", {31'd0, rx_warn_flag}, 32'd1);
    step("R7");
    chk("R7 irq follows flag", {31'd0, irq}, 32'd1);

    tx_err_cnt = 8'd10; bus_off = 1; step("R5");
    tx_err_cnt = 8'd200; step("R5");
    chk("R5 no tx set in bus-off", {31'd0, tx_warn_flag}, 32'd0);
    bus_off = 0; tx_err_cnt = 8'd10; step("R5");

    warn_en = 0; step("R3");
    chk("R3 rx hidden", {31'd0, rx_warn_flag}, 32'd0);
    chk("R3 status hidden", status_word, 32'h0004_0000);
    tx_err_cnt = 8'd97; step("R3");
    warn_en = 1; step("R3");
    chk("R3 rx reappears", {31'd0, rx_warn_flag}, 32'd1);
    chk("R3 tx not set while disabled", {31'd0, tx_warn_flag}, 32'd0);

    tx_err_cnt = 8'd0; step("R6");
    freeze = 1; tx_err_cnt = 8'd150; wr(0, 1); step("R6");
    wr_en = 0; step("R6");
    chk("R6 no set in freeze", {31'd0, tx_warn_flag}, 32'd0);
    chk("R6 no clear in freeze", {31'd0, rx_warn_flag}, 32'd1);
    freeze = 0; step("R6");
    chk("R6 late set after freeze", {31'd0, tx_warn_flag}, 32'd1);

    rx_err_cnt = 8'd20; step("R8");
    rx_err_cnt = 8'd99; wr(0, 1); step("R8");
    wr_en = 0;
    chk("R8 set beats clear", {31'd0, rx_warn_flag}, 32'd1);

    for (int i = 0; i < 3000; i++) begin
      tx_err_cnt = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(90, 101));
      rx_err_cnt = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(90, 101));
      warn_en = $urandom_range(0, 9) != 0;
      tx_mask = 1'($urandom); rx_mask = 1'($urandom);
      bus_off = $urandom_range(0, 7) == 0;
      freeze = $urandom_range(0, 9) == 0;
      synced = 1'($urandom);
      wr_en = $urandom_range(0, 3) == 0;
      wr_data = $urandom;
      step("R2 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule